// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is one general-purpose I/O port. It drives up to 32 pads with output data and a per-pin output enable. It samples the same pads through a two-stage synchronizer and turns pin activity into interrupts. Software reaches it over a simple single-cycle register bus. Reads return data in the same cycle, and writes take effect at the next clock edge.

Every writable register sits in its own 16-byte slot. Each slot has three write views:
- a plain view that replaces the whole register;
- a set view that ORs in the written ones;
- a clear view that removes the written ones.

These views let several software agents change single pins without a read-modify-write race. Each pin has its own interrupt controls:
- an interrupt-source select;
- an enable;
- a two-bit trigger mode (edge or level, with a polarity);
- a sticky status bit.

All 32 enabled status bits are ORed onto one interrupt line for the port.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is 0. This means no pad is driven (pad_oe = 0), `irq` is low, and reads of every slot return 0 until pad activity reaches the input slot.
- R2: The slot is addr[7:4]: 0 output data, 1 input data, 2 output enable, 3 interrupt-source select, 4 interrupt enable, 5 trigger level, 6 trigger polarity, 7 status. The write view is addr[3:2]: 0 replace, 1 set, 2 clear, 3 no effect. A read returns the slot's register whatever addr[3:2] holds. Slots 8 to 15 read 0 and ignore writes.
- R3: A write through the set view ORs `bus_wdata` into the register. A write through the clear view clears the bits written as 1. No other bit changes.
- R4: The input-data slot returns `pad_in` delayed by two clock edges. Writes to that slot have no effect.
- R5: `pad_oe` equals the output-enable register. `pad_out` carries the output-data bit where that enable is 1 and 0 elsewhere. Neither changes without a bus write.
- R6: The per-pin mode is {polarity, level}. In mode 10, a rising synchronized input sets the status bit; in mode 00, a falling one sets it. A pad change applied before clock edge k is visible in status after edge k+2.
- R7: In mode 11 (high) or 01 (low), the status bit is set on every cycle in which the synchronized input is at the active level.
- R8: A status bit is never set while the pin's interrupt-source select bit is 0.
- R9: Status bits are sticky. Only a write of 1s through the status clear view (slot 7, view 2) clears them. Replace and set writes to status have no effect.
- R10: `irq` is high exactly when some pin has both its status bit and its enable bit at 1. A disabled pin still records status.
- R11: Changing the polarity bit of an edge-mode pin makes it respond to the opposite edge from the next cycle on.
- R12: When a status clear and a new trigger fall on the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 8 | Byte address: slot in [7:4], write view in [3:2] |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables; 0 releases the pad |
| irq | output | 1 | Combined port interrupt |

## Verification
The trigger logic is exercised with these pin patterns:
- a group of pins rising while a second group falls, which shows whether rising-edge and falling-edge pins each react only to their own transition;
- a pin held steadily high and a pin held steadily low, which separates level behaviour (status re-sets after every clear) from edge behaviour (one set per transition);
- toggles on pins whose source select is off, and a polarity change in the middle of a sequence, which show that gating and edge direction follow the register contents cycle by cycle.

The register file is driven through all three write views and through unused slots and views. This separates replace, OR and AND-NOT behaviour from writes that must do nothing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Write view selected by address bits [3:2]
    typedef enum logic [1:0] {
        ACC_REPLACE = 2'd0,
        ACC_SET     = 2'd1,
        ACC_CLEAR   = 2'd2,
        ACC_NONE    = 2'd3
    } acc_e;

    localparam int NSLOT   = 8;
    localparam int SL_DOUT = 0;
    localparam int SL_DIN  = 1;
    localparam int SL_OE   = 2;
    localparam int SL_SEL  = 3;
    localparam int SL_EN   = 4;
    localparam int SL_LEV  = 5;
    localparam int SL_POL  = 6;
    localparam int SL_STAT = 7;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    output logic [NSLOT-1:0]      wr_hit,
    output acc_e                  acc,
    output logic [ADDR_W-5:0]     rd_slot,
    output logic                  rd_valid
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic              unused_lo;

    assign slot      = addr[ADDR_W-1:4];
    assign acc       = acc_e'(addr[3:2]);
    assign rd_slot   = slot;
    assign rd_valid  = (slot < SLOT_W'(NSLOT));
    assign unused_lo = ^addr[1:0];

    for (genvar i = 0; i < NSLOT; i++) begin : g_hit
        assign wr_hit[i] = req && we && (slot == SLOT_W'(i));
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = pin_i;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] lev_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic trig;
        always_comb begin
            unique case ({pol_i[i], lev_i[i]})
                2'b00:   trig = !sync_i[i] &&  prev_i[i];  // falling edge
                2'b01:   trig = !sync_i[i];                // low level
                2'b10:   trig =  sync_i[i] && !prev_i[i];  // rising edge
                default: trig =  sync_i[i];                // high level
            endcase
        end
        assign hit_o[i] = sel_i[i] && trig;
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam int SLOT_W = ADDR_W - 4;

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] sel;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] lev;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] stat;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [NSLOT-1:0]  wr_hit;
    acc_e              acc;
    logic [SLOT_W-1:0] rd_slot;
    logic              rd_valid;
    logic [NPINS-1:0]  sync_w, prev_w, hit_w, clr_w;

    // Plain views of state for the bound checker
    logic [NPINS-1:0]  stat_w, sel_w, lev_w, pol_w;
    assign stat_w = regs_q.stat;
    assign sel_w  = regs_q.sel;
    assign lev_w  = regs_q.lev;
    assign pol_w  = regs_q.pol;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .wr_hit   (wr_hit),
        .acc      (acc),
        .rd_slot  (rd_slot),
        .rd_valid (rd_valid)
    );

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_ni (rst_ni),
        .pin_i  (pad_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .sync_i (sync_w),
        .prev_i (prev_w),
        .sel_i  (regs_q.sel),
        .lev_i  (regs_q.lev),
        .pol_i  (regs_q.pol),
        .hit_o  (hit_w)
    );

    function automatic logic [NPINS-1:0] apply_acc(
        input acc_e             a,
        input logic [NPINS-1:0] cur,
        input logic [NPINS-1:0] wd
    );
        unique case (a)
            ACC_REPLACE: return wd;
            ACC_SET:     return cur | wd;
            ACC_CLEAR:   return cur & ~wd;
            default:     return cur;
        endcase
    endfunction

    assign clr_w = (wr_hit[SL_STAT] && acc == ACC_CLEAR) ? bus_wdata : '0;

    always_comb begin
        regs_d = regs_q;
        if (wr_hit[SL_DOUT]) regs_d.dout = apply_acc(acc, regs_q.dout, bus_wdata);
        if (wr_hit[SL_OE])   regs_d.oe   = apply_acc(acc, regs_q.oe,   bus_wdata);
        if (wr_hit[SL_SEL])  regs_d.sel  = apply_acc(acc, regs_q.sel,  bus_wdata);
        if (wr_hit[SL_EN])   regs_d.en   = apply_acc(acc, regs_q.en,   bus_wdata);
        if (wr_hit[SL_LEV])  regs_d.lev  = apply_acc(acc, regs_q.lev,  bus_wdata);
        if (wr_hit[SL_POL])  regs_d.pol  = apply_acc(acc, regs_q.pol,  bus_wdata);
        // Status: only the clear view removes bits; a new trigger wins
        regs_d.stat = (regs_q.stat & ~clr_w) | hit_w;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_valid) begin
            unique case (int'(rd_slot))
                SL_DOUT: bus_rdata = regs_q.dout;
                SL_DIN:  bus_rdata = sync_w;
                SL_OE:   bus_rdata = regs_q.oe;
                SL_SEL:  bus_rdata = regs_q.sel;
                SL_EN:   bus_rdata = regs_q.en;
                SL_LEV:  bus_rdata = regs_q.lev;
                SL_POL:  bus_rdata = regs_q.pol;
                default: bus_rdata = regs_q.stat;
            endcase
        end
    end

    assign pad_oe  = regs_q.oe;
    assign pad_out = regs_q.dout & regs_q.oe;
    assign irq     = |(regs_q.stat & regs_q.en);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int NPINS = 32,
    parameter int NHIT  = 8
) (
    input logic             clk,
    input logic             rst_ni,
    input logic             bus_req,
    input logic             bus_we,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] sel_q,
    input logic [NPINS-1:0] lev_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] sync_v,
    input logic [NHIT-1:0]  wr_hit
);
    // R2
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $onehot0(wr_hit));

    // R5
    pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        !(bus_req && bus_we) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        !(bus_req && bus_we) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R8
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0));

    // R7
    high_level_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        ((sel_q & lev_q & pol_q & sync_v) != '0) |=>
        ((stat_q & $past(sel_q & lev_q & pol_q & sync_v)) == $past(sel_q & lev_q & pol_q & sync_v)));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .NHIT(gpio_irq_pkg::NSLOT)) u_chk (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .bus_req (bus_req),
    .bus_we  (bus_we),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .stat_q  (stat_w),
    .sel_q   (sel_w),
    .lev_q   (lev_w),
    .pol_q   (pol_w),
    .sync_v  (sync_w),
    .wr_hit  (wr_hit)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    logic        clk = 1'b0;
    logic        rst_ni;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pad_in, pad_out, pad_oe;
    logic        irq;

    always #5 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_ni(rst_ni), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 0;
    string phase   = "R1";

    // Behavioural reference: register array indexed by slot, pin history queue
    logic [31:0] m_reg [8];
    logic [31:0] hist [$] = '{32'h0, 32'h0, 32'h0};

    always @(posedge clk) begin
        logic [31:0] s, p, setv, clrv;
        int slot, view;
        if (!rst_ni) begin
            for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            s = hist[1];
            p = hist[2];
            setv = 32'h0;
            clrv = 32'h0;
            for (int b = 0; b < 32; b++) begin
                if (m_reg[3][b]) begin
                    case ({m_reg[6][b], m_reg[5][b]})
                        2'b00: setv[b] = p[b] & ~s[b];
                        2'b01: setv[b] = ~s[b];
                        2'b10: setv[b] = s[b] & ~p[b];
                        default: setv[b] = s[b];
                    endcase
                end
            end
            slot = int'(bus_addr[7:4]);
            view = int'(bus_addr[3:2]);
            if (bus_req && bus_we && slot < 8) begin
                if (slot == 7) begin
                    if (view == 2) clrv = bus_wdata;
                end else if (slot != 1) begin
                    if (view == 0) m_reg[slot] = bus_wdata;
                    else if (view == 1) m_reg[slot] = m_reg[slot] | bus_wdata;
                    else if (view == 2) m_reg[slot] = m_reg[slot] & ~bus_wdata;
                end
            end
            m_reg[7] = (m_reg[7] & ~clrv) | setv;
            hist.push_front(pad_in);
            void'(hist.pop_back());
        end
    end

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // Wait for the next falling edge and compare every output with the model
    task automatic tick();
        logic [31:0] exp_rd;
        int slot;
        @(negedge clk);
        slot = int'(bus_addr[7:4]);
        if (slot >= 8)      exp_rd = 32'h0;
        else if (slot == 1) exp_rd = hist[1];
        else                exp_rd = m_reg[slot];
        vectors++;
        cmp("rdata",   bus_rdata, exp_rd);
        cmp("pad_oe",  pad_oe,  m_reg[2]);
        cmp("pad_out", pad_out, m_reg[0] & m_reg[2]);
        cmp("irq",     {31'h0, irq}, {31'h0, |(m_reg[7] & m_reg[4])});
    endtask

    // Model-independent literal check
    task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s literal: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int slot, int view, logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = {slot[3:0], view[1:0], 2'b00};
        bus_wdata = d;
        tick();
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(int slot, int view);
        bus_req = 1'b1; bus_we = 1'b0;
        bus_addr = {slot[3:0], view[1:0], 2'b00};
        tick();
        bus_req = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic watch_status();
        bus_addr = 8'h70;
    endtask

    initial begin
        rst_ni = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = 8'h70; bus_wdata = 32'h0; pad_in = 32'h0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        phase = "R1";
        for (int s = 0; s < 16; s++) begin
            rd(s, 0);
            expect_val("R1", bus_rdata, 32'h0);
        end
        expect_val("R1", {31'h0, irq}, 32'h0);

        phase = "R3";
        wr(0, 0, 32'hA5A5_0F0F);
        wr(0, 1, 32'h0000_F000);
        wr(0, 2, 32'h0500_0001);
        rd(0, 0);
        expect_val("R3", bus_rdata, 32'hA0A5_FF0E);

        phase = "R2";
        wr(0, 3, 32'hFFFF_FFFF);
        rd(0, 2);
        expect_val("R2", bus_rdata, 32'hA0A5_FF0E);
        wr(9, 0, 32'hFFFF_FFFF);
        rd(9, 0);
        expect_val("R2", bus_rdata, 32'h0);
        rd(15, 1);

        phase = "R5";
        wr(2, 0, 32'h0000_FFFF);
        expect_val("R5", pad_out, 32'h0000_FF0E);
        wr(2, 1, 32'hFF00_0000);
        wr(2, 2, 32'h0000_00F0);
        idle(3);

        phase = "R4";
        pad_in = 32'h1234_5678;
        rd(1, 0);
        rd(1, 0);
        expect_val("R4", bus_rdata, 32'h1234_5678);
        wr(1, 0, 32'h0);
        wr(1, 2, 32'hFFFF_FFFF);
        rd(1, 0);
        pad_in = 32'hCAFE_0001;
        idle(1);
        rd(1, 1);
        pad_in = 32'h0;
        idle(3);

        phase = "R6";
        wr(3, 0, 32'hFFFF_FFFF);
        wr(5, 0, 32'h0);
        wr(6, 0, 32'h0000_FFFF);
        wr(7, 2, 32'hFFFF_FFFF);
        watch_status();
        pad_in = 32'h0000_00FF;
        tick(); tick();
        expect_val("R6", bus_rdata, 32'h0);
        tick();
        expect_val("R6", bus_rdata, 32'h0000_00FF);
        pad_in = 32'hFFFF_00FF;
        idle(4);
        pad_in = 32'h0000_0000;
        idle(4);
        expect_val("R6", bus_rdata, 32'hFFFF_00FF);

        phase = "R10";
        wr(4, 0, 32'h0001_0000);
        expect_val("R10", {31'h0, irq}, 32'h1);
        wr(7, 2, 32'h0001_0000);
        watch_status();
        idle(1);
        expect_val("R10", {31'h0, irq}, 32'h0);
        wr(7, 2, 32'hFFFF_FFFF);
        watch_status();
        idle(2);

        phase = "R9";
        wr(7, 0, 32'h0);
        wr(7, 1, 32'hFFFF_FFFF);
        wr(7, 3, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0003;
        watch_status();
        idle(4);
        wr(7, 0, 32'h0);
        wr(7, 1, 32'h0);
        watch_status();
        tick();
        expect_val("R9", bus_rdata, 32'h0000_0003);
        wr(7, 2, 32'h0000_0001);
        watch_status();
        tick();
        expect_val("R9", bus_rdata, 32'h0000_0002);

        phase = "R7";
        wr(7, 2, 32'hFFFF_FFFF);
        wr(5, 1, 32'h0010_0100);
        pad_in = 32'h0000_0100;
        watch_status();
        idle(4);
        expect_val("R7", bus_rdata & 32'h0010_0100, 32'h0010_0100);

        phase = "R12";
        wr(7, 2, 32'h0010_0100);
        watch_status();
        expect_val("R12", bus_rdata & 32'h0010_0100, 32'h0010_0100);
        pad_in = 32'h0010_0000;
        idle(4);
        wr(7, 2, 32'hFFFF_FFFF);
        watch_status();
        idle(1);
        expect_val("R7", bus_rdata, 32'h0);
        wr(5, 2, 32'h0010_0100);
        pad_in = 32'h0;
        idle(4);

        phase = "R8";
        wr(7, 2, 32'hFFFF_FFFF);
        wr(3, 2, 32'h0000_00F0);
        watch_status();
        pad_in = 32'h0000_00F0;
        idle(4);
        pad_in = 32'h0;
        idle(4);
        expect_val("R8", bus_rdata, 32'h0);

        phase = "R11";
        wr(6, 2, 32'h0000_0001);
        watch_status();
        pad_in = 32'h0000_0001;
        idle(4);
        expect_val("R11", bus_rdata, 32'h0);
        pad_in = 32'h0;
        idle(4);
        expect_val("R11", bus_rdata, 32'h0000_0001);
        wr(6, 1, 32'h0000_0001);
        wr(7, 2, 32'hFFFF_FFFF);
        watch_status();
        pad_in = 32'h0000_0001;
        idle(4);
        expect_val("R11", bus_rdata, 32'h0000_0001);

        phase = "R5";
        wr(0, 0, 32'hFFFF_FFFF);
        wr(2, 0, 32'h8000_0001);
        expect_val("R5", pad_out, 32'h8000_0001);
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule